// File: doc/BRIEF.md
# Call and Interrupt Stack Sequencer

This block owns the stack pointer of a small processor core and runs the short memory sequences that save and restore control state. A procedure call saves the return address. A procedure return gets it back. Interrupt entry saves the flags, the code segment and the instruction pointer. Interrupt return restores those three values in reverse order. Plain pushes and pops of a single data word use the same machinery.

The core presents a one-hot command with the current register values and a target address. The block then drives one word access per cycle on a simple memory port. It finishes with a single-cycle `done`, and the restored values are already on its outputs when `done` is high. The stack grows downward in byte addresses, two bytes per word. Saved entries unwind in last-in-first-out order, so nested calls and nested interrupts return correctly. The core can load the stack pointer directly while the block is idle.

Top module: `callstack_seq`

## Requirements
- R1: After reset, `sp` equals the parameter `SP_RST` (default 0x0100). `busy`, `done`, `cmd_reject` and all restored outputs are 0.
- R2: A push step writes its word at address `sp-2`. After that step `sp` equals the written address, so the pointer moves down before the write.
- R3: A pop step reads the word at the current `sp`. `mem_rdata` is taken in the same cycle that `mem_re` is high. After that step `sp` is the read address plus 2.
- R4: `cmd_op` bit 0 (CALL) pushes `cur_ip` as the only access and sets `ip_out` to `cmd_target`. `done` rises in the first cycle after the access cycle.
- R5: `cmd_op` bit 1 (RET) pops one word into `ip_out`.
- R6: `cmd_op` bit 2 (INT) pushes `cur_fr`, then `cur_cs`, then `cur_ip`, in three back-to-back cycles. It then sets `ip_out` to `cmd_target` and leaves `sp` 6 lower.
- R7: `cmd_op` bit 3 (IRET) pops into `ip_out`, then `cs_out`, then `fr_out`, in three back-to-back cycles. It leaves `sp` 6 higher.
- R8: `cmd_op` bit 4 (PUSH) pushes `push_data`. `cmd_op` bit 5 (POP) pops one word into `pop_out`.
- R9: A command is accepted only when the block is idle, `cmd_op` is one-hot and `sp_load` is low. Any other command is rejected: `cmd_reject` pulses in the next cycle, and neither `sp` nor memory changes.
- R10: While the block is idle, `sp_load` loads `sp_load_val` into `sp`. While the block is busy, `sp_load` is ignored.
- R11: All stack-pointer arithmetic wraps modulo 2^16.
- R12: Nested CALL/INT sequences unwind in reverse order through RET/IRET, and each one gets back its own saved values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 6 | One-hot operation: bit 0 CALL, 1 RET, 2 INT, 3 IRET, 4 PUSH, 5 POP |
| cmd_target | input | 16 | New IP for CALL and INT |
| cur_ip | input | 16 | Current instruction pointer |
| cur_cs | input | 16 | Current code segment |
| cur_fr | input | 16 | Current flags word |
| push_data | input | 16 | Word for PUSH |
| sp_load | input | 1 | Direct stack-pointer load strobe |
| sp_load_val | input | 16 | Value for direct load |
| mem_addr | output | 16 | Byte address of the stack word |
| mem_we | output | 1 | Word write strobe |
| mem_re | output | 1 | Word read strobe |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the cycle of `mem_re` |
| busy | output | 1 | A sequence is running |
| cmd_reject | output | 1 | Pulse: the previous cycle's command was refused |
| done | output | 1 | Pulse: the sequence has completed |
| sp | output | 16 | Current stack pointer |
| ip_out | output | 16 | Restored or loaded instruction pointer |
| cs_out | output | 16 | Restored code segment |
| fr_out | output | 16 | Restored flags word |
| pop_out | output | 16 | Word returned by POP |

## Verification
A wrong step counter or a wrong operation register appears right away as the wrong number of memory strobes. It also appears as a `done` that comes one or more cycles early or late, so the fault is visible within the three-cycle window of a single sequence. A stack pointer that is off by one step shows on the very next access: the address is wrong for a write, and the wrong word comes back for a read. It also leaves `sp` different from where it started once a balanced pair of commands has finished. Sweeping start pointers that straddle zero, and nesting calls inside interrupts, exposes wrap and ordering faults within a few commands.

// File: rtl/stk_pkg.sv
`timescale 1ns/1ps
package stk_pkg;
  localparam int OP_N    = 6;
  localparam int OP_CALL = 0;
  localparam int OP_RET  = 1;
  localparam int OP_INT  = 2;
  localparam int OP_IRET = 3;
  localparam int OP_PUSH = 4;
  localparam int OP_POP  = 5;
  localparam int STEP_W  = 2;
  localparam int WORD_BYTES = 2;
  typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;
endpackage

// File: rtl/stk_rst_sync.sv
`timescale 1ns/1ps
module stk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/stk_sp_unit.sv
`timescale 1ns/1ps
module stk_sp_unit #(
  parameter int AW = 16,
  parameter logic [AW-1:0] SP_RST = 16'h0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          dec,
  input  logic          inc,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] sp_m2
);
  import stk_pkg::*;
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  logic [AW-1:0] sp_q, sp_d;
  logic          sp_en;

  assign sp_m2 = sp_q - STEP;
  assign sp_en = ld | dec | inc;

  always_comb begin
    sp_d = sp_q;
    if (ld)       sp_d = ld_val;
    else if (dec) sp_d = sp_m2;
    else if (inc) sp_d = sp_q + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= SP_RST;
    else if (sp_en) sp_q <= sp_d;
  end

  assign sp = sp_q;

  assert_one_sp_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld, dec, inc}));
endmodule

// File: rtl/stk_seq.sv
`timescale 1ns/1ps
module stk_seq #(
  parameter int DW = 16,
  parameter int AW = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  input  logic [stk_pkg::OP_N-1:0] cmd_op,
  input  logic [DW-1:0]           cmd_target,
  input  logic [DW-1:0]           cur_ip,
  input  logic [DW-1:0]           cur_cs,
  input  logic [DW-1:0]           cur_fr,
  input  logic [DW-1:0]           push_data,
  input  logic                    sp_load,
  input  logic [AW-1:0]           sp,
  input  logic [AW-1:0]           sp_m2,
  output logic                    busy,
  output logic                    cmd_reject,
  output logic                    done,
  output logic                    sp_dec,
  output logic                    sp_inc,
  output logic [AW-1:0]           mem_addr,
  output logic                    mem_we,
  output logic                    mem_re,
  output logic [DW-1:0]           mem_wdata,
  output logic                    cap_ip,
  output logic                    cap_cs,
  output logic                    cap_fr,
  output logic                    cap_pop,
  output logic                    ld_tgt,
  output logic [DW-1:0]           tgt
);
  import stk_pkg::*;
  localparam logic [STEP_W-1:0] LAST_MULTI = STEP_W'(2);

  seq_state_e        st_q, st_d;
  logic [OP_N-1:0]   op_q;
  logic [STEP_W-1:0] step_q, step_d;
  logic [DW-1:0]     ip_q, cs_q, fr_q, tgt_q, pd_q;
  logic              done_q, done_d, rej_q, rej_d;
  logic              running, accept, is_push, is_pop, multi, last;

  assign running = (st_q == ST_RUN);
  assign accept  = !running && cmd_valid && $onehot(cmd_op) && !sp_load;
  assign rej_d   = cmd_valid && !accept;
  assign is_push = op_q[OP_CALL] | op_q[OP_INT]  | op_q[OP_PUSH];
  assign is_pop  = op_q[OP_RET]  | op_q[OP_IRET] | op_q[OP_POP];
  assign multi   = op_q[OP_INT]  | op_q[OP_IRET];
  assign last    = multi ? (step_q == LAST_MULTI) : 1'b1;

  // next state
  always_comb begin
    st_d   = st_q;
    step_d = step_q;
    done_d = 1'b0;
    if (accept) begin
      st_d   = ST_RUN;
      step_d = '0;
    end else if (running) begin
      step_d = step_q + 1'b1;
      if (last) begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end
    end
  end

  // memory step decode
  always_comb begin
    mem_we    = running && is_push;
    mem_re    = running && is_pop;
    mem_addr  = is_push ? sp_m2 : sp;
    mem_wdata = pd_q;
    if (op_q[OP_CALL]) mem_wdata = ip_q;
    if (op_q[OP_INT]) begin
      case (step_q)
        2'd0:    mem_wdata = fr_q;
        2'd1:    mem_wdata = cs_q;
        default: mem_wdata = ip_q;
      endcase
    end
    cap_ip  = running && (op_q[OP_RET] || (op_q[OP_IRET] && step_q == 2'd0));
    cap_cs  = running && op_q[OP_IRET] && (step_q == 2'd1);
    cap_fr  = running && op_q[OP_IRET] && (step_q == 2'd2);
    cap_pop = running && op_q[OP_POP];
    ld_tgt  = running && last && (op_q[OP_CALL] || op_q[OP_INT]);
  end

  assign sp_dec = mem_we;
  assign sp_inc = mem_re;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
      done_q <= 1'b0;
      rej_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      done_q <= done_d;
      rej_q  <= rej_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= '0;
      ip_q  <= '0;
      cs_q  <= '0;
      fr_q  <= '0;
      tgt_q <= '0;
      pd_q  <= '0;
    end else if (accept) begin
      op_q  <= cmd_op;
      ip_q  <= cur_ip;
      cs_q  <= cur_cs;
      fr_q  <= cur_fr;
      tgt_q <= cmd_target;
      pd_q  <= push_data;
    end
  end

  assign busy       = running;
  assign done       = done_q;
  assign cmd_reject = rej_q;
  assign tgt        = tgt_q;

  assert_single_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_reject_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |-> $past(cmd_valid));
endmodule

// File: rtl/stk_restore.sv
`timescale 1ns/1ps
module stk_restore #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_ip,
  input  logic          cap_cs,
  input  logic          cap_fr,
  input  logic          cap_pop,
  input  logic          ld_tgt,
  input  logic [DW-1:0] tgt,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] ip_out,
  output logic [DW-1:0] cs_out,
  output logic [DW-1:0] fr_out,
  output logic [DW-1:0] pop_out
);
  logic [DW-1:0] ip_q, cs_q, fr_q, pop_q, ip_d;
  logic          ip_en;

  assign ip_en = ld_tgt | cap_ip;
  assign ip_d  = ld_tgt ? tgt : rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip_q  <= '0;
      cs_q  <= '0;
      fr_q  <= '0;
      pop_q <= '0;
    end else begin
      if (ip_en)   ip_q  <= ip_d;
      if (cap_cs)  cs_q  <= rdata;
      if (cap_fr)  fr_q  <= rdata;
      if (cap_pop) pop_q <= rdata;
    end
  end

  assign ip_out  = ip_q;
  assign cs_out  = cs_q;
  assign fr_out  = fr_q;
  assign pop_out = pop_q;

  assert_capture_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ip_en, cap_cs, cap_fr, cap_pop}));
endmodule

// File: rtl/callstack_seq.sv
`timescale 1ns/1ps
module callstack_seq #(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter logic [AW-1:0] SP_RST = 16'h0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [5:0]    cmd_op,
  input  logic [DW-1:0] cmd_target,
  input  logic [DW-1:0] cur_ip,
  input  logic [DW-1:0] cur_cs,
  input  logic [DW-1:0] cur_fr,
  input  logic [DW-1:0] push_data,
  input  logic          sp_load,
  input  logic [AW-1:0] sp_load_val,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          cmd_reject,
  output logic          done,
  output logic [AW-1:0] sp,
  output logic [DW-1:0] ip_out,
  output logic [DW-1:0] cs_out,
  output logic [DW-1:0] fr_out,
  output logic [DW-1:0] pop_out
);
  logic          rst_s;
  logic          sp_dec, sp_inc, sp_ld;
  logic          cap_ip, cap_cs, cap_fr, cap_pop, ld_tgt;
  logic [AW-1:0] sp_m2;
  logic [DW-1:0] tgt;

  stk_rst_sync i_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s));

  assign sp_ld = sp_load && !busy;

  stk_sp_unit #(.AW(AW), .SP_RST(SP_RST)) i_sp (
    .clk(clk), .rst_n(rst_s), .ld(sp_ld), .ld_val(sp_load_val),
    .dec(sp_dec), .inc(sp_inc), .sp(sp), .sp_m2(sp_m2));

  stk_seq #(.DW(DW), .AW(AW)) i_seq (
    .clk(clk), .rst_n(rst_s), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_target(cmd_target), .cur_ip(cur_ip), .cur_cs(cur_cs), .cur_fr(cur_fr),
    .push_data(push_data), .sp_load(sp_load), .sp(sp), .sp_m2(sp_m2),
    .busy(busy), .cmd_reject(cmd_reject), .done(done),
    .sp_dec(sp_dec), .sp_inc(sp_inc), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_re(mem_re), .mem_wdata(mem_wdata), .cap_ip(cap_ip), .cap_cs(cap_cs),
    .cap_fr(cap_fr), .cap_pop(cap_pop), .ld_tgt(ld_tgt), .tgt(tgt));

  stk_restore #(.DW(DW)) i_rest (
    .clk(clk), .rst_n(rst_s), .cap_ip(cap_ip), .cap_cs(cap_cs), .cap_fr(cap_fr),
    .cap_pop(cap_pop), .ld_tgt(ld_tgt), .tgt(tgt), .rdata(mem_rdata),
    .ip_out(ip_out), .cs_out(cs_out), .fr_out(fr_out), .pop_out(pop_out));

  assert_write_moves_sp_R2: assert property (@(posedge clk) disable iff (!rst_s)
    mem_we |=> (sp == $past(mem_addr)));
  assert_read_moves_sp_R3: assert property (@(posedge clk) disable iff (!rst_s)
    mem_re |=> (sp == $past(mem_addr) + AW'(2)));
  assert_access_only_busy_R9: assert property (@(posedge clk) disable iff (!rst_s)
    (mem_we || mem_re) |-> busy);
  assert_busy_load_ignored_R10: assert property (@(posedge clk) disable iff (!rst_s)
    (busy && !mem_we && !mem_re) |=> $stable(sp));
endmodule

// File: tb/test_callstack_seq.sv
`timescale 1ns/1ps
module test_callstack_seq;
  localparam logic [5:0] C_CALL = 6'b000001, C_RET = 6'b000010, C_INT = 6'b000100,
                         C_IRET = 6'b001000, C_PUSH = 6'b010000, C_POP = 6'b100000;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, sp_load, mem_we, mem_re, busy, cmd_reject, done;
  logic [5:0]  cmd_op;
  logic [15:0] cmd_target, cur_ip, cur_cs, cur_fr, push_data, sp_load_val;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, sp, ip_out, cs_out, fr_out, pop_out;
  logic [15:0] mem_b [0:255];
  logic [15:0] la [0:63];
  logic [15:0] lw [0:63];
  int nw = 0;
  int ntot = 0;
  int nbad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  callstack_seq i_callstack_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_target(cmd_target), .cur_ip(cur_ip), .cur_cs(cur_cs), .cur_fr(cur_fr),
    .push_data(push_data), .sp_load(sp_load), .sp_load_val(sp_load_val),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .cmd_reject(cmd_reject), .done(done),
    .sp(sp), .ip_out(ip_out), .cs_out(cs_out), .fr_out(fr_out), .pop_out(pop_out));

  assign mem_rdata = mem_b[mem_addr[8:1]];

  always @(posedge clk) begin
    if (mem_we) begin
      mem_b[mem_addr[8:1]] <= mem_wdata;
      la[nw % 64] <= mem_addr;
      lw[nw % 64] <= mem_wdata;
      nw <= nw + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    ntot++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic load_sp(input logic [15:0] v);
    @(negedge clk); sp_load = 1'b1; sp_load_val = v;
    @(negedge clk); sp_load = 1'b0;
  endtask

  task automatic run(input logic [5:0] op, input logic [15:0] t, input logic [15:0] ip,
                     input logic [15:0] cs, input logic [15:0] fr, input logic [15:0] pd,
                     output int lat);
    @(negedge clk);
    cmd_op = op; cmd_target = t; cur_ip = ip; cur_cs = cs; cur_fr = fr; push_data = pd;
    cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!done && lat < 20);
  endtask

  initial begin
    #500000;
    ntot++; nbad++;
    $display("FAIL watchdog act=0 exp=1");
    if (!finished) $display("  test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end

  initial begin
    logic [15:0] sps [4];
    logic [15:0] s, a, b, c;
    int lat, w0;
    string tg;
    sps = '{16'h0100, 16'h0002, 16'h0000, 16'h0004};
    rst_n = 1'b0; cmd_valid = 1'b0; sp_load = 1'b0; cmd_op = '0; cmd_target = '0;
    cur_ip = '0; cur_cs = '0; cur_fr = '0; push_data = '0; sp_load_val = '0;
    for (int k = 0; k < 256; k++) mem_b[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(sp == 16'h0100, "R1 sp", sp, 16'h0100);
    chk(!busy && !done && !cmd_reject, "R1 flags", {busy, done, cmd_reject}, 0);
    chk(ip_out == 0 && cs_out == 0 && fr_out == 0 && pop_out == 0, "R1 outs", ip_out, 0);

    for (int i = 0; i < 4; i++) begin
      s = sps[i];
      tg = (s < 16'h0006) ? "R11" : "R2";
      load_sp(s);
      chk(sp == s, "R10 load", sp, s);
      // CALL / RET
      a = 16'h1230 + 16'(i); b = 16'h4000 + 16'(i);
      w0 = nw;
      run(C_CALL, b, a, 16'h0, 16'h0, 16'h0, lat);
      chk(lat == 1, "R4 latency", lat, 1);
      chk(nw == w0 + 1, "R4 writes", nw - w0, 1);
      chk(la[w0 % 64] == s - 16'd2, {tg, " call addr"}, la[w0 % 64], s - 16'd2);
      chk(lw[w0 % 64] == a, "R4 saved ip", lw[w0 % 64], a);
      chk(sp == s - 16'd2, {tg, " call sp"}, sp, s - 16'd2);
      chk(ip_out == b, "R4 ip_out", ip_out, b);
      run(C_RET, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, lat);
      chk(ip_out == a, "R5 ip_out", ip_out, a);
      chk(sp == s, "R3 ret sp", sp, s);
      chk(lat == 1 && nw == w0 + 1, "R5 single read", lat, 1);
      // INT / IRET
      a = 16'h1000 + 16'(i * 3); b = 16'hC000 + 16'(i); c = 16'hF000 + 16'(i);
      w0 = nw;
      run(C_INT, 16'h8000 + 16'(i), a, b, c, 16'h0, lat);
      chk(lat == 3, "R6 latency", lat, 3);
      chk(nw == w0 + 3, "R6 writes", nw - w0, 3);
      chk(la[w0 % 64] == s - 16'd2 && lw[w0 % 64] == c, {tg, " R6 fr slot"}, {la[w0 % 64], lw[w0 % 64]}, {s - 16'd2, c});
      chk(la[(w0 + 1) % 64] == s - 16'd4 && lw[(w0 + 1) % 64] == b, "R6 cs slot", {la[(w0 + 1) % 64], lw[(w0 + 1) % 64]}, {s - 16'd4, b});
      chk(la[(w0 + 2) % 64] == s - 16'd6 && lw[(w0 + 2) % 64] == a, "R6 ip slot", {la[(w0 + 2) % 64], lw[(w0 + 2) % 64]}, {s - 16'd6, a});
      chk(sp == s - 16'd6, {tg, " R6 sp"}, sp, s - 16'd6);
      chk(ip_out == 16'h8000 + 16'(i), "R6 ip_out", ip_out, 16'h8000 + 16'(i));
      run(C_IRET, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, lat);
      chk(lat == 3, "R7 latency", lat, 3);
      chk(ip_out == a && cs_out == b && fr_out == c, "R7 restore", {ip_out, cs_out}, {a, b});
      chk(fr_out == c, "R7 fr", fr_out, c);
      chk(sp == s, {tg, " R7 sp"}, sp, s);
      // PUSH / POP
      a = 16'hA5A0 + 16'(i);
      run(C_PUSH, 16'h0, 16'h0, 16'h0, 16'h0, a, lat);
      chk(sp == s - 16'd2 && lw[(nw - 1) % 64] == a, "R8 push", sp, s - 16'd2);
      run(C_POP, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, lat);
      chk(pop_out == a && sp == s, "R8 pop", pop_out, a);
    end

    // R12 nesting
    load_sp(16'h0100);
    run(C_CALL, 16'h2000, 16'h0111, 16'h0, 16'h0, 16'h0, lat);
    run(C_INT, 16'h3000, 16'h0222, 16'h0333, 16'h0044, 16'h0, lat);
    run(C_CALL, 16'h2100, 16'h0555, 16'h0, 16'h0, 16'h0, lat);
    chk(sp == 16'h00F6, "R12 depth", sp, 16'h00F6);
    run(C_RET, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, lat);
    chk(ip_out == 16'h0555, "R12 inner ret", ip_out, 16'h0555);
    run(C_IRET, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, lat);
    chk(ip_out == 16'h0222 && cs_out == 16'h0333 && fr_out == 16'h0044, "R12 iret", ip_out, 16'h0222);
    run(C_RET, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, lat);
    chk(ip_out == 16'h0111 && sp == 16'h0100, "R12 outer ret", ip_out, 16'h0111);

    // R9 command while busy
    load_sp(16'h0080);
    w0 = nw;
    @(negedge clk);
    cmd_op = C_INT; cmd_target = 16'h0; cur_ip = 16'h1; cur_cs = 16'h2; cur_fr = 16'h3;
    cmd_valid = 1'b1;
    @(negedge clk); cmd_op = C_CALL;
    @(negedge clk);
    chk(cmd_reject == 1'b1, "R9 busy reject", cmd_reject, 1);
    cmd_valid = 1'b0;
    lat = 0;
    while (!done && lat < 20) begin @(negedge clk); lat++; end
    chk(nw == w0 + 3 && sp == 16'h007A, "R9 no extra effect", sp, 16'h007A);
    // R9 non-one-hot
    w0 = nw;
    @(negedge clk); cmd_op = 6'b000011; cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0;
    chk(cmd_reject == 1'b1 && busy == 1'b0, "R9 bad op", {cmd_reject, busy}, 2);
    @(negedge clk);
    chk(sp == 16'h007A && nw == w0 && !done, "R9 bad op no effect", sp, 16'h007A);

    // R10 load wins over a command in the same idle cycle
    @(negedge clk); sp_load = 1'b1; sp_load_val = 16'h0040; cmd_op = C_PUSH; cmd_valid = 1'b1;
    @(negedge clk); sp_load = 1'b0; cmd_valid = 1'b0;
    chk(cmd_reject == 1'b1 && sp == 16'h0040, "R10 load priority", sp, 16'h0040);
    @(negedge clk);
    chk(nw == w0 && !busy, "R10 no push", nw - w0, 0);
    // R10 load ignored while busy
    @(negedge clk); cmd_op = C_PUSH; push_data = 16'h7777; cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0; sp_load = 1'b1; sp_load_val = 16'h0200;
    @(negedge clk); sp_load = 1'b0;
    chk(sp == 16'h003E, "R10 busy load ignored", sp, 16'h003E);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end
endmodule